// File: doc/BRIEF.md
# GPIO Bank Controller with Interrupt and Wake Detection

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32, and every register kind is repeated once per bank. Each pin has an output-enable bit and an output value. The output value changes only through two write-only ports: one sets bits and the other clears them. Software reads the synchronised input state through a read-only level word.

Every pin feeds an event detector. The detector can work in edge mode, with separate rising and falling enables, or in level mode, with a polarity choice. A glitch filter with a parameterised hold time sits in front of the detector, and each pin can bypass it. A detected event sets two independent status bits, one for interrupt and one for wake. Each status bit has its own mask. The block drives one combined interrupt line and one combined wake line.

Host access uses a simple single-cycle request bus. Writes take effect at the clock edge of the request. Read data appears on `rdata_o` one cycle after a read request and holds until the next read.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration register, output value and status bit is 0, so `pin_oe_o`, `pin_o`, `irq_o` and `wake_o` are all low.
- R2: Pin n maps to bit n%32 of the word at base + 4*(n/32). The bases are: level 0x004 (read-only), output-enable 0x01C, set 0x034, clear 0x04C, rising enable 0x064, falling enable 0x07C, filter bypass 0x094, interrupt mask 0x0AC, interrupt status 0x0C4, detect type 0x300, level polarity 0x318, wake mask 0x400 and wake status 0x418. Read data is returned one cycle after the request. The set and clear ports and any unmapped address read as 0.
- R3: Writing 1 to a bit of the set port drives that pin's output value to 1. Writing 1 to a bit of the clear port drives it to 0. Bits written as 0 are left unchanged.
- R4: An output-enable bit of 1 makes the pin an output (`pin_oe_o` high), and 0 makes it an input.
- R5: The level word reports each pin's input after a two-flop synchroniser, whatever the pin's direction and filter setting.
- R6: With detect type 0 (edge), a rising transition sets the status when the rising enable is 1, and a falling transition sets it when the falling enable is 1. Both enables may be set on one pin. Status stays set until 1 is written to its bit.
- R7: With detect type 1 (level), the status bit equals the active level, and a write of 1 does not clear it while that level remains. A polarity bit of 0 means active-high and 1 means active-low.
- R8: With bypass 0, a new input level reaches the detector only after the synchronised input has differed from the accepted level for FILT_CYCLES consecutive cycles, so shorter pulses are dropped. With bypass 1, single-cycle pulses are detected.
- R9: `irq_o` is high exactly when some interrupt status bit and its mask bit are both 1.
- R10: Every detected event also sets the wake status, which is cleared by writing 1 and is independent of the interrupt mask. `wake_o` is high exactly when some wake status bit and its wake mask bit are both 1.
- R11: Bit positions at or beyond NUM_PINS in the last bank read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| pin_o | output | NUM_PINS | Output values |
| pin_oe_o | output | NUM_PINS | Output enables |
| irq_o | output | 1 | Combined masked interrupt |
| wake_o | output | 1 | Combined masked wake |

## Verification
If one output value bit is corrupted, `pin_o` shows it in the cycle after the bus write. If a filter counter holds a bad value, a status bit is set too early or not at all. That error becomes visible at the first status read after a pulse whose width is near FILT_CYCLES, which is why the bench sends pulses of FILT_CYCLES-1 and FILT_CYCLES cycles. A status bit stuck at 1 or stuck at 0 shows on `irq_o` or `wake_o` as soon as its mask is set, and it also shows at the next status read. In level mode, an incorrect status appears within a few cycles of the pin changing.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned BANK_W     = 32;
  localparam int unsigned OFS_LEVEL  = 'h004;
  localparam int unsigned OFS_DIR    = 'h01C;
  localparam int unsigned OFS_SET    = 'h034;
  localparam int unsigned OFS_CLR    = 'h04C;
  localparam int unsigned OFS_RISE   = 'h064;
  localparam int unsigned OFS_FALL   = 'h07C;
  localparam int unsigned OFS_BYP    = 'h094;
  localparam int unsigned OFS_IMASK  = 'h0AC;
  localparam int unsigned OFS_ISTAT  = 'h0C4;
  localparam int unsigned OFS_ITYPE  = 'h300;
  localparam int unsigned OFS_LPOL   = 'h318;
  localparam int unsigned OFS_WMASK  = 'h400;
  localparam int unsigned OFS_WSTAT  = 'h418;

  function automatic logic [BANK_W-1:0] bank_valid(int unsigned num_pins, int unsigned idx);
    logic [BANK_W-1:0] m;
    for (int unsigned i = 0; i < BANK_W; i++)
      m[i] = (idx * BANK_W + i) < num_pins;
    return m;
  endfunction
endpackage

// File: rtl/gpio_irq_pin_cond.sv
module gpio_irq_pin_cond #(
  parameter int unsigned FILT_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic bypass_i,
  output logic sync_o,
  output logic level_o
);
  localparam int unsigned CNT_W = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic             s1_q, s2_q, flt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  // accept a new level only after FILT_CYCLES cycles of disagreement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= 1'b0;
      cnt_q <= '0;
    end else if (bypass_i || (s2_q == flt_q)) begin
      flt_q <= s2_q;
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      flt_q <= s2_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sync_o  = s2_q;
  assign level_o = flt_q;

  generate
    if (FILT_CYCLES > 1) begin : g_chk
      assert_filter_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bypass_i && (s2_q != $past(s2_q))) |=> $stable(flt_q));
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned       BANK_IDX    = 0,
  parameter logic [BANK_W-1:0] VALID_MASK  = '1,
  parameter int unsigned       FILT_CYCLES = 4,
  parameter int unsigned       ADDR_W      = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [BANK_W-1:0] pin_i,
  output logic [BANK_W-1:0] pin_o,
  output logic [BANK_W-1:0] pin_oe_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned STEP = 4 * BANK_IDX;
  localparam logic [ADDR_W-1:0] A_LVL   = ADDR_W'(OFS_LEVEL + STEP);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR   + STEP);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET   + STEP);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR   + STEP);
  localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(OFS_RISE  + STEP);
  localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(OFS_FALL  + STEP);
  localparam logic [ADDR_W-1:0] A_BYP   = ADDR_W'(OFS_BYP   + STEP);
  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(OFS_IMASK + STEP);
  localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT + STEP);
  localparam logic [ADDR_W-1:0] A_ITYPE = ADDR_W'(OFS_ITYPE + STEP);
  localparam logic [ADDR_W-1:0] A_LPOL  = ADDR_W'(OFS_LPOL  + STEP);
  localparam logic [ADDR_W-1:0] A_WMASK = ADDR_W'(OFS_WMASK + STEP);
  localparam logic [ADDR_W-1:0] A_WSTAT = ADDR_W'(OFS_WSTAT + STEP);

  logic [BANK_W-1:0] dir_q, out_q, rise_q, fall_q, byp_q, imask_q;
  logic [BANK_W-1:0] itype_q, lpol_q, wmask_q, istat_q, wstat_q, prv_q;
  logic [BANK_W-1:0] sync_v, flt_v, wv, w1c_i, w1c_w;
  logic [BANK_W-1:0] edge_ev, active, istat_d, wstat_d;
  logic              wr;
  logic h_lvl, h_dir, h_set, h_clr, h_rise, h_fall, h_byp;
  logic h_imask, h_istat, h_itype, h_lpol, h_wmask, h_wstat;

  assign wr      = req_i & we_i;
  assign wv      = wdata_i & VALID_MASK;
  assign h_lvl   = req_i && (addr_i == A_LVL);
  assign h_dir   = req_i && (addr_i == A_DIR);
  assign h_set   = req_i && (addr_i == A_SET);
  assign h_clr   = req_i && (addr_i == A_CLR);
  assign h_rise  = req_i && (addr_i == A_RISE);
  assign h_fall  = req_i && (addr_i == A_FALL);
  assign h_byp   = req_i && (addr_i == A_BYP);
  assign h_imask = req_i && (addr_i == A_IMASK);
  assign h_istat = req_i && (addr_i == A_ISTAT);
  assign h_itype = req_i && (addr_i == A_ITYPE);
  assign h_lpol  = req_i && (addr_i == A_LPOL);
  assign h_wmask = req_i && (addr_i == A_WMASK);
  assign h_wstat = req_i && (addr_i == A_WSTAT);

  generate
    for (genvar i = 0; i < BANK_W; i++) begin : g_pin
      gpio_irq_pin_cond #(.FILT_CYCLES(FILT_CYCLES)) u_cond (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pin_i    (pin_i[i] & VALID_MASK[i]),
        .bypass_i (byp_q[i]),
        .sync_o   (sync_v[i]),
        .level_o  (flt_v[i])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      out_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      byp_q   <= '0;
      imask_q <= '0;
      itype_q <= '0;
      lpol_q  <= '0;
      wmask_q <= '0;
    end else if (wr) begin
      if (h_dir)   dir_q   <= wv;
      if (h_set)   out_q   <= out_q | wv;
      if (h_clr)   out_q   <= out_q & ~wv;
      if (h_rise)  rise_q  <= wv;
      if (h_fall)  fall_q  <= wv;
      if (h_byp)   byp_q   <= wv;
      if (h_imask) imask_q <= wv;
      if (h_itype) itype_q <= wv;
      if (h_lpol)  lpol_q  <= wv;
      if (h_wmask) wmask_q <= wv;
    end
  end

  assign w1c_i   = (wr && h_istat) ? wv : '0;
  assign w1c_w   = (wr && h_wstat) ? wv : '0;
  assign edge_ev = (flt_v & ~prv_q & rise_q) | (~flt_v & prv_q & fall_q);
  assign active  = (flt_v ^ lpol_q) & VALID_MASK;
  // level mode: status tracks the active level; edge mode: sticky, event beats clear
  assign istat_d = (itype_q & active) | (~itype_q & ((istat_q & ~w1c_i) | edge_ev));
  assign wstat_d = (itype_q & active) | (~itype_q & ((wstat_q & ~w1c_w) | edge_ev));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prv_q   <= '0;
      istat_q <= '0;
      wstat_q <= '0;
    end else begin
      prv_q   <= flt_v;
      istat_q <= istat_d;
      wstat_q <= wstat_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (h_lvl)   rdata_o = sync_v & VALID_MASK;
    if (h_dir)   rdata_o = dir_q;
    if (h_rise)  rdata_o = rise_q;
    if (h_fall)  rdata_o = fall_q;
    if (h_byp)   rdata_o = byp_q;
    if (h_imask) rdata_o = imask_q;
    if (h_istat) rdata_o = istat_q;
    if (h_itype) rdata_o = itype_q;
    if (h_lpol)  rdata_o = lpol_q;
    if (h_wmask) rdata_o = wmask_q;
    if (h_wstat) rdata_o = wstat_q;
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(istat_q & imask_q);
  assign wake_o   = |(wstat_q & wmask_q);

  assert_set_drives_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && h_set) |=> ((pin_o & $past(wv)) == $past(wv)));
  assert_clr_drives_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && h_clr) |=> ((pin_o & $past(wv)) == '0));
  assert_istat_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(istat_q) & ~$past(w1c_i) & ~$past(itype_q) & ~istat_q) == '0));
  assert_wstat_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(wstat_q) & ~$past(w1c_w) & ~$past(itype_q) & ~wstat_q) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 48,
  parameter int unsigned FILT_CYCLES = 4,
  parameter int unsigned ADDR_W      = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o,
  output logic                wake_o
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int unsigned PAD_W     = NUM_BANKS * BANK_W;

  logic [PAD_W-1:0]     pin_pad, out_pad, oe_pad;
  logic [BANK_W-1:0]    bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq, bank_wake;
  logic [31:0]          rd_any, rdata_q;

  assign pin_pad = PAD_W'(pin_i);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      gpio_irq_bank #(
        .BANK_IDX    (b),
        .VALID_MASK  (bank_valid(NUM_PINS, b)),
        .FILT_CYCLES (FILT_CYCLES),
        .ADDR_W      (ADDR_W)
      ) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req_i),
        .we_i     (we_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .rdata_o  (bank_rd[b]),
        .pin_i    (pin_pad[b*BANK_W +: BANK_W]),
        .pin_o    (out_pad[b*BANK_W +: BANK_W]),
        .pin_oe_o (oe_pad[b*BANK_W +: BANK_W]),
        .irq_o    (bank_irq[b]),
        .wake_o   (bank_wake[b])
      );
    end
  endgenerate

  always_comb begin
    rd_any = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_any = rd_any | bank_rd[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (req_i && !we_i)   rdata_q <= rd_any;
  end

  assign rdata_o  = rdata_q;
  assign pin_o    = out_pad[NUM_PINS-1:0];
  assign pin_oe_o = oe_pad[NUM_PINS-1:0];
  assign irq_o    = |bank_irq;
  assign wake_o   = |bank_wake;

  generate
    if (PAD_W > NUM_PINS) begin : g_pad_chk
      assert_pad_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_pad[PAD_W-1:NUM_PINS] == '0) && (oe_pad[PAD_W-1:NUM_PINS] == '0));
    end
  endgenerate
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int NP   = 48;
  localparam int FILT = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pin_o, pin_oe_o;
  logic        irq_o, wake_o;

  int n_cmp = 0;
  int n_bad = 0;

  localparam int A_LVL = 'h004, A_DIR = 'h01C, A_SET = 'h034, A_CLR = 'h04C;
  localparam int A_RISE = 'h064, A_FALL = 'h07C, A_BYP = 'h094, A_IMASK = 'h0AC;
  localparam int A_ISTAT = 'h0C4, A_ITYPE = 'h300, A_LPOL = 'h318;
  localparam int A_WMASK = 'h400, A_WSTAT = 'h418;

  always #2 clk_i = ~clk_i;

  gpio_irq_ctrl #(.NUM_PINS(NP), .FILT_CYCLES(FILT), .ADDR_W(12)) i_gpio_irq_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pin_i(pins), .pin_o, .pin_oe_o, .irq_o, .wake_o
  );

  function automatic logic [31:0] vmask(int b);
    return (b == 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic exp_edge(logic old_v, logic new_v, logic r, logic f);
    return (old_v != new_v) && ((new_v && r) || (!new_v && f));
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 12'(a); wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 12'(a);
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic zero_cfg();
    for (int b = 0; b < 2; b++) begin
      wr(A_RISE + 4*b, 0);  wr(A_FALL + 4*b, 0);  wr(A_ITYPE + 4*b, 0);
      wr(A_LPOL + 4*b, 0);  wr(A_IMASK + 4*b, 0); wr(A_WMASK + 4*b, 0);
      wr(A_BYP + 4*b, 0);
    end
    for (int b = 0; b < 2; b++) begin
      wr(A_ISTAT + 4*b, '1); wr(A_WSTAT + 4*b, '1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] shadow [8][2];
    logic [NP-1:0] out_exp;
    int cfg_ofs [8];
    void'($urandom(32'd20211));
    cfg_ofs = '{A_DIR, A_RISE, A_FALL, A_BYP, A_IMASK, A_ITYPE, A_LPOL, A_WMASK};
    for (int k = 0; k < 8; k++) for (int b = 0; b < 2; b++) shadow[k][b] = '0;

    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 pin_oe", 64'(pin_oe_o), 0);
    chk("R1 pin_o", 64'(pin_o), 0);
    chk("R1 irq", 64'(irq_o), 0);
    chk("R1 wake", 64'(wake_o), 0);
    for (int k = 0; k < 8; k++) begin
      rd(cfg_ofs[k] + 4, d);
      chk("R1 cfg reset", 64'(d), 0);
    end

    // R2 R11 R4 register access and padding
    wr(A_DIR + 4, '1);
    rd(A_DIR + 4, d);
    chk("R11 pad bits", 64'(d), 64'h0000_FFFF);
    chk("R4 pin_oe bank1", 64'(pin_oe_o), {16'h0, 16'hFFFF, 32'h0});
    wr(A_DIR + 4, 0);
    shadow[0][1] = 0;
    for (int it = 0; it < 24; it++) begin
      int k = int'($urandom_range(7, 0));
      int b = int'($urandom_range(1, 0));
      logic [31:0] v = $urandom();
      wr(cfg_ofs[k] + 4*b, v);
      shadow[k][b] = v & vmask(b);
    end
    for (int k = 0; k < 8; k++) for (int b = 0; b < 2; b++) begin
      rd(cfg_ofs[k] + 4*b, d);
      chk("R2 readback", 64'(d), 64'(shadow[k][b]));
    end
    chk("R4 pin_oe", 64'(pin_oe_o), 64'({shadow[0][1][15:0], shadow[0][0]}));
    rd(A_SET, d);   chk("R2 set reads 0", 64'(d), 0);
    rd(A_CLR + 4, d); chk("R2 clr reads 0", 64'(d), 0);
    rd('h200, d);   chk("R2 unmapped", 64'(d), 0);
    wr(A_DIR, 0); wr(A_DIR + 4, 0);
    zero_cfg();

    // R3 set/clear ports
    out_exp = '0;
    for (int it = 0; it < 20; it++) begin
      int b = int'($urandom_range(1, 0));
      logic [31:0] v = $urandom();
      logic s = 1'($urandom_range(1, 0));
      logic [NP-1:0] vv = (b == 0) ? NP'(v) : NP'({v[15:0], 32'h0});
      wr((s ? A_SET : A_CLR) + 4*b, v);
      out_exp = s ? (out_exp | vv) : (out_exp & ~vv);
      chk("R3 pin_o", 64'(pin_o), 64'(out_exp));
    end

    // R5 level word
    for (int it = 0; it < 4; it++) begin
      pins = {$urandom(), $urandom()};
      idle(3);
      rd(A_LVL, d);     chk("R5 level bank0", 64'(d), 64'(pins[31:0]));
      rd(A_LVL + 4, d); chk("R5 level bank1", 64'(d), 64'({16'h0, pins[47:32]}));
    end
    idle(10);
    zero_cfg();

    // R6 R9 R10 random edge detection
    for (int it = 0; it < 30; it++) begin
      int p = int'($urandom_range(NP - 1, 0));
      int b = p / 32;
      int bit_i = p % 32;
      logic r = 1'($urandom_range(1, 0));
      logic f = 1'($urandom_range(1, 0));
      logic im = 1'($urandom_range(1, 0));
      logic wm = 1'($urandom_range(1, 0));
      logic nv = 1'($urandom_range(1, 0));
      logic ov = pins[p];
      logic e;
      wr(A_RISE + 4*b, 32'(r) << bit_i);
      wr(A_FALL + 4*b, 32'(f) << bit_i);
      wr(A_IMASK + 4*b, 32'(im) << bit_i);
      wr(A_WMASK + 4*b, 32'(wm) << bit_i);
      wr(A_BYP + 4*b, 32'($urandom()));
      wr(A_ISTAT + 4*b, '1);
      wr(A_WSTAT + 4*b, '1);
      @(negedge clk_i); pins[p] = nv;
      idle(14);
      e = exp_edge(ov, nv, r, f);
      rd(A_ISTAT + 4*b, d); chk("R6 edge status", 64'(d), 64'(32'(e) << bit_i));
      rd(A_WSTAT + 4*b, d); chk("R10 wake status", 64'(d), 64'(32'(e) << bit_i));
      chk("R9 irq", 64'(irq_o), 64'(e && im));
      chk("R10 wake", 64'(wake_o), 64'(e && wm));
      wr(A_RISE + 4*b, 0); wr(A_FALL + 4*b, 0);
      wr(A_IMASK + 4*b, 0); wr(A_WMASK + 4*b, 0);
      wr(A_ISTAT + 4*b, '1); wr(A_WSTAT + 4*b, '1);
    end
    // both edges on one pin (R6)
    pins[3] = 1'b0; idle(12);
    wr(A_RISE, 32'h8); wr(A_FALL, 32'h8); wr(A_ISTAT, '1);
    pins[3] = 1'b1; idle(12);
    rd(A_ISTAT, d); chk("R6 both rise", 64'(d), 64'h8);
    wr(A_ISTAT, 32'h8);
    rd(A_ISTAT, d); chk("R6 w1c", 64'(d), 0);
    pins[3] = 1'b0; idle(12);
    rd(A_ISTAT, d); chk("R6 both fall", 64'(d), 64'h8);
    zero_cfg();

    // R7 level mode
    pins[5] = 1'b0; idle(12);
    wr(A_ITYPE, 32'h20); wr(A_IMASK, 32'h20);
    idle(2);
    rd(A_ISTAT, d); chk("R7 inactive", 64'(d), 0);
    pins[5] = 1'b1; idle(12);
    rd(A_ISTAT, d); chk("R7 active high", 64'(d), 64'h20);
    chk("R9 irq level", 64'(irq_o), 1);
    wr(A_ISTAT, 32'h20);
    rd(A_ISTAT, d); chk("R7 w1c no effect", 64'(d), 64'h20);
    pins[5] = 1'b0; idle(12);
    rd(A_ISTAT, d); chk("R7 follows low", 64'(d), 0);
    chk("R9 irq off", 64'(irq_o), 0);
    wr(A_LPOL, 32'h20); idle(2);
    rd(A_ISTAT, d); chk("R7 active low", 64'(d), 64'h20);
    zero_cfg();

    // R8 glitch filter, pin 40 = bank1 bit 8
    pins[40] = 1'b0; idle(12);
    wr(A_RISE + 4, 32'h100); wr(A_ISTAT + 4, '1);
    @(negedge clk_i); pins[40] = 1'b1; idle(FILT - 1); pins[40] = 1'b0;
    idle(15);
    rd(A_ISTAT + 4, d); chk("R8 short pulse dropped", 64'(d), 0);
    @(negedge clk_i); pins[40] = 1'b1; idle(FILT); pins[40] = 1'b0;
    idle(15);
    rd(A_ISTAT + 4, d); chk("R8 FILT pulse accepted", 64'(d), 64'h100);
    wr(A_ISTAT + 4, '1);
    wr(A_BYP + 4, 32'h100);
    @(negedge clk_i); pins[40] = 1'b1; idle(1); pins[40] = 1'b0;
    idle(10);
    rd(A_ISTAT + 4, d); chk("R8 bypass pulse", 64'(d), 64'h100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule